// File: doc/BRIEF.md
# Ethernet Port Status Indicator and GPIO Controller

This block drives three pins that either show the state of a 10/100 Ethernet port on active-low LEDs or serve as general-purpose I/O. Pin 0 shows the line rate, pin 1 shows link presence and traffic, and pin 2 shows the duplex mode. Each pin takes one of four modes from a configuration register, which is written with a one-cycle write strobe. The modes are input, push-pull output, open-drain output and LED. A pin in LED mode only pulls low or floats, so the LED works with a pull-up to any rail.

The link pin stays lit while the link is up. When transmit or receive traffic is seen, it goes dark for one blink interval. It then stays lit for at least one more interval before it can blink again. Traffic that arrives during a blink or during the hold that follows is remembered, and it causes exactly one further blink. The interval is `CLK_HZ/1000 * BLINK_MS` clock cycles, counted by a millisecond prescaler. Every pad value passes through a two-flop synchronizer before it can be read.

Top module: `eth_status_led_ctl`

## Requirements
- R1: After reset, all three pins are in input mode with `pad_oe_o` = 0. The traffic sequencer is idle with nothing pending, so the link pin is lit as soon as it is placed in LED mode with the link up.
- R2: When `cfg_wr_i` is high at a clock edge, the mode of pin i is loaded from `cfg_mode_i[2i+1:2i]` and its output value from `cfg_dout_i[i]`. The mode codes are 0 input, 1 push-pull, 2 open-drain and 3 LED. In push-pull mode, `pad_oe_o[i]` = 1 and `pad_o[i]` equals the stored output value.
- R3: In open-drain GPIO mode, `pad_o[i]` = 0 and `pad_oe_o[i]` is the inverse of the stored output value. In input mode, `pad_oe_o[i]` = 0.
- R4: In LED mode, a lit LED gives `pad_oe_o` = 1 with `pad_o` = 0, and a dark LED gives `pad_oe_o` = 0. The pin never drives high in this mode.
- R5: The rate LED on pin 0 is dark only when the link is up at 10 Mb/s with auto-negotiation idle. It is lit at 100 Mb/s, during auto-negotiation and when the link is down.
- R6: The link LED on pin 1 is lit while the link is up and no blink is in progress. It is dark while the link is down, and traffic seen while the link is down starts no blink.
- R7: A traffic strobe (`tx_act_i` or `rx_act_i`) sampled while the link is up and the sequencer is idle darkens pin 1 from the next clock edge.
- R8: Each dark period is followed by a lit hold of one full interval. Traffic during the hold does not cut the hold short.
- R9: Any number of strobes during a dark period or a hold are latched as one pending request. That request starts exactly one new dark period at the clock edge that ends the hold.
- R10: When the link drops, pin 1 goes dark in the same cycle, the sequence is aborted and the pending request is cleared. When the link returns, pin 1 is lit steadily.
- R11: The duplex LED on pin 2 is lit only when the link is up in full duplex.
- R12: `gpio_in_o[i]` shows `pad_i[i]` as it was two clock edges earlier, and stays unchanged one edge after the pad changes.
- R13: Each dark period and each hold lasts exactly `CLK_HZ/1000 * BLINK_MS` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_i | input | 1 | Load the configuration register |
| cfg_mode_i | input | 6 | Two-bit mode per pin |
| cfg_dout_i | input | 3 | GPIO output value per pin |
| phy_link_i | input | 1 | Link up |
| phy_spd100_i | input | 1 | Link runs at 100 Mb/s |
| phy_aneg_i | input | 1 | Auto-negotiation in progress |
| phy_fdx_i | input | 1 | Full duplex |
| tx_act_i | input | 1 | Transmit activity strobe |
| rx_act_i | input | 1 | Receive activity strobe |
| pad_i | input | 3 | Pad input values |
| pad_o | output | 3 | Pad output data |
| pad_oe_o | output | 3 | Pad output enable |
| gpio_in_o | output | 3 | Synchronized pad input values |

## Verification
The bench measures the exact length of each dark period and each hold. A prescaler that is off by one would make the blink one cycle too long or too short. Strobes are placed both inside a dark period and inside a hold. A design that blinks twice, cuts the hold short or drops the request would show the wrong pin 1 level at the probed cycles. The bench also drops the link while a request is pending. A design that keeps the stale request would blink again after the link returns. Each LED state is also checked in LED mode, so a pin that drives high while its LED is dark is caught.

// File: rtl/eth_led_pkg.sv
package eth_led_pkg;

    typedef enum logic [1:0] {
        PIN_IN  = 2'd0,
        PIN_PP  = 2'd1,
        PIN_OD  = 2'd2,
        PIN_LED = 2'd3
    } pin_mode_e;

    typedef enum logic [1:0] {
        ACT_IDLE = 2'd0,
        ACT_DARK = 2'd1,
        ACT_HOLD = 2'd2
    } act_state_e;

    typedef struct packed {
        logic dout;
        logic oe;
    } pin_drv_t;

    localparam int PIN_SPEED  = 0;
    localparam int PIN_LINK   = 1;
    localparam int PIN_DUPLEX = 2;

    function automatic pin_drv_t drive_for(pin_mode_e mode, logic gval, logic led_n);
        pin_drv_t d;
        d.dout = 1'b0;
        d.oe   = 1'b0;
        case (mode)
            PIN_PP:  begin d.dout = gval; d.oe = 1'b1; end
            PIN_OD:  d.oe = ~gval;
            PIN_LED: d.oe = ~led_n;
            default: d.oe = 1'b0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/led_interval_timer.sv
module led_interval_timer #(
    parameter int CLK_HZ   = 125_000_000,
    parameter int BLINK_MS = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic clr_i,
    output logic done_o
);
    localparam int CYC_PER_MS = (CLK_HZ / 1000 > 0) ? CLK_HZ / 1000 : 1;
    localparam int MS_CNT     = (BLINK_MS > 0) ? BLINK_MS : 1;
    localparam int SUB_W      = $clog2(CYC_PER_MS > 1 ? CYC_PER_MS : 2);
    localparam int MS_W       = $clog2(MS_CNT > 1 ? MS_CNT : 2);
    localparam int TOTAL      = CYC_PER_MS * MS_CNT;

    logic [SUB_W-1:0] sub_q;
    logic [MS_W-1:0]  ms_q;
    logic             run_q;
    logic             sub_end;
    logic             ms_end;

    assign sub_end = (sub_q == SUB_W'(CYC_PER_MS - 1));
    assign ms_end  = (ms_q == MS_W'(MS_CNT - 1));
    assign done_o  = run_q && sub_end && ms_end;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            sub_q <= '0;
            ms_q  <= '0;
            run_q <= 1'b0;
        end else if (start_i) begin
            sub_q <= '0;
            ms_q  <= '0;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (done_o) begin
                run_q <= 1'b0;
            end else if (sub_end) begin
                sub_q <= '0;
                ms_q  <= ms_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    generate
        if (TOTAL > 1) begin : g_chk
            a_r13_no_done_after_start: assert property (@(posedge clk) disable iff (rst)
                (start_i && !clr_i) |=> !done_o);
        end
    endgenerate

endmodule

// File: rtl/link_act_fsm.sv
module link_act_fsm
    import eth_led_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic link_i,
    input  logic act_i,
    input  logic done_i,
    output logic start_o,
    output logic led_n_o
);
    act_state_e st_q, st_d;
    logic       pend_q, pend_d;

    always_comb begin
        st_d    = st_q;
        pend_d  = pend_q;
        start_o = 1'b0;
        if (!link_i) begin
            st_d   = ACT_IDLE;
            pend_d = 1'b0;
        end else begin
            case (st_q)
                ACT_IDLE: begin
                    if (act_i) begin
                        st_d    = ACT_DARK;
                        start_o = 1'b1;
                    end
                end
                ACT_DARK: begin
                    if (act_i) pend_d = 1'b1;
                    if (done_i) begin
                        st_d    = ACT_HOLD;
                        start_o = 1'b1;
                    end
                end
                ACT_HOLD: begin
                    if (act_i) pend_d = 1'b1;
                    if (done_i) begin
                        if (pend_q || act_i) begin
                            st_d    = ACT_DARK;
                            start_o = 1'b1;
                            pend_d  = 1'b0;
                        end else begin
                            st_d = ACT_IDLE;
                        end
                    end
                end
                default: st_d = ACT_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ACT_IDLE;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
        end
    end

    assign led_n_o = !link_i || (st_q == ACT_DARK);

    // R9: a pending request only exists while a blink sequence is running
    a_r9_pending_only_busy: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> (st_q != ACT_IDLE));

    a_r7_dark_needs_cause: assert property (@(posedge clk) disable iff (rst)
        (st_q == ACT_DARK && $past(st_q) != ACT_DARK) |-> $past(act_i || pend_q));

    a_r8_hold_after_dark: assert property (@(posedge clk) disable iff (rst)
        ($past(st_q) == ACT_DARK && st_q != ACT_DARK && $past(link_i)) |-> (st_q == ACT_HOLD));

    a_r10_drop_clears: assert property (@(posedge clk) disable iff (rst)
        !$past(link_i) |-> (st_q == ACT_IDLE && !pend_q));

endmodule

// File: rtl/pin_mux.sv
module pin_mux
    import eth_led_pkg::*;
#(
    parameter int NPINS = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [2*NPINS-1:0] mode_i,
    input  logic [NPINS-1:0]   gval_i,
    input  logic [NPINS-1:0]   led_n_i,
    input  logic [NPINS-1:0]   pad_i,
    output logic [NPINS-1:0]   pad_o,
    output logic [NPINS-1:0]   pad_oe_o,
    output logic [NPINS-1:0]   gpio_in_o
);
    logic [NPINS-1:0] sync1_q;
    logic [NPINS-1:0] sync2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= pad_i;
            sync2_q <= sync1_q;
        end
    end

    assign gpio_in_o = sync2_q;

    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            pin_mode_e mode;
            pin_drv_t  drv;
            assign mode        = pin_mode_e'(mode_i[2*i +: 2]);
            assign drv         = drive_for(mode, gval_i[i], led_n_i[i]);
            assign pad_o[i]    = drv.dout;
            assign pad_oe_o[i] = drv.oe;

            a_r4_led_never_high: assert property (@(posedge clk) disable iff (rst)
                (mode == PIN_LED) |-> !(pad_oe_o[i] && pad_o[i]));

            a_r3_input_released: assert property (@(posedge clk) disable iff (rst)
                (mode == PIN_IN) |-> !pad_oe_o[i]);
        end
    endgenerate

endmodule

// File: rtl/eth_status_led_ctl.sv
module eth_status_led_ctl
    import eth_led_pkg::*;
#(
    parameter int CLK_HZ   = 125_000_000,
    parameter int BLINK_MS = 80
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr_i,
    input  logic [5:0] cfg_mode_i,
    input  logic [2:0] cfg_dout_i,
    input  logic       phy_link_i,
    input  logic       phy_spd100_i,
    input  logic       phy_aneg_i,
    input  logic       phy_fdx_i,
    input  logic       tx_act_i,
    input  logic       rx_act_i,
    input  logic [2:0] pad_i,
    output logic [2:0] pad_o,
    output logic [2:0] pad_oe_o,
    output logic [2:0] gpio_in_o
);
    localparam int NPINS = 3;

    logic [2*NPINS-1:0] mode_q;
    logic [NPINS-1:0]   gval_q;
    logic [NPINS-1:0]   led_n;
    logic               start;
    logic               done;
    logic               link_led_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= {NPINS{PIN_IN}};
            gval_q <= '0;
        end else if (cfg_wr_i) begin
            mode_q <= cfg_mode_i;
            gval_q <= cfg_dout_i;
        end
    end

    led_interval_timer #(
        .CLK_HZ  (CLK_HZ),
        .BLINK_MS(BLINK_MS)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start_i(start),
        .clr_i  (!phy_link_i),
        .done_o (done)
    );

    link_act_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .link_i (phy_link_i),
        .act_i  (tx_act_i || rx_act_i),
        .done_i (done),
        .start_o(start),
        .led_n_o(link_led_n)
    );

    always_comb begin
        led_n[PIN_SPEED]  = phy_link_i && !phy_spd100_i && !phy_aneg_i;
        led_n[PIN_LINK]   = link_led_n;
        led_n[PIN_DUPLEX] = !(phy_link_i && phy_fdx_i);
    end

    pin_mux #(.NPINS(NPINS)) u_pins (
        .clk      (clk),
        .rst      (rst),
        .mode_i   (mode_q),
        .gval_i   (gval_q),
        .led_n_i  (led_n),
        .pad_i    (pad_i),
        .pad_o    (pad_o),
        .pad_oe_o (pad_oe_o),
        .gpio_in_o(gpio_in_o)
    );

    a_r1_reset_all_inputs: assert property (@(posedge clk)
        $past(rst) |-> (pad_oe_o == 3'b000));

    a_r6_link_down_dark: assert property (@(posedge clk) disable iff (rst)
        (mode_q[2*PIN_LINK +: 2] == PIN_LED && !phy_link_i) |-> !pad_oe_o[PIN_LINK]);

endmodule

// File: tb/test_eth_status_led_ctl.sv
module test_eth_status_led_ctl;
    localparam int CLK_HZ   = 4000;
    localparam int BLINK_MS = 2;
    localparam int IVL      = (CLK_HZ / 1000) * BLINK_MS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [5:0] cfg_mode = '0;
    logic [2:0] cfg_dout = '0;
    logic       link = 1'b0, spd = 1'b0, aneg = 1'b0, fdx = 1'b0;
    logic       tx = 1'b0, rx = 1'b0;
    logic [2:0] pad_in = '0;
    logic [2:0] pad_o, pad_oe, gin;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #4 clk = ~clk;

    eth_status_led_ctl #(.CLK_HZ(CLK_HZ), .BLINK_MS(BLINK_MS)) i_eth_status_led_ctl (
        .clk(clk), .rst(rst), .cfg_wr_i(cfg_wr), .cfg_mode_i(cfg_mode), .cfg_dout_i(cfg_dout),
        .phy_link_i(link), .phy_spd100_i(spd), .phy_aneg_i(aneg), .phy_fdx_i(fdx),
        .tx_act_i(tx), .rx_act_i(rx), .pad_i(pad_in),
        .pad_o(pad_o), .pad_oe_o(pad_oe), .gpio_in_o(gin)
    );

    // Vector: [18:13] mode, [12:10] dout, [9:6] {link,spd100,aneg,fdx}, [5:3] exp pad_o, [2:0] exp pad_oe
    // Mode codes 0 input, 1 push-pull, 2 open-drain, 3 LED; pin0 rate, pin1 link, pin2 duplex.
    localparam int NV = 8;
    localparam logic [18:0] VEC [NV] = '{
        {6'b01_01_01, 3'b101, 4'b0000, 3'b101, 3'b111},  // R2 push-pull
        {6'b10_10_10, 3'b101, 4'b0000, 3'b000, 3'b010},  // R3 open-drain
        {6'b11_11_11, 3'b000, 4'b1101, 3'b000, 3'b111},  // R4 R5 R11 100M full
        {6'b11_11_11, 3'b000, 4'b1000, 3'b000, 3'b010},  // R5 R11 10M half
        {6'b11_11_11, 3'b000, 4'b1011, 3'b000, 3'b111},  // R5 aneg
        {6'b11_11_11, 3'b000, 4'b0001, 3'b000, 3'b001},  // R5 R6 R11 link down
        {6'b10_00_01, 3'b110, 4'b0000, 3'b000, 3'b001},  // R2 R3 mixed
        {6'b00_01_11, 3'b010, 4'b1000, 3'b010, 3'b010}   // R2 R5 mixed
    };

    function automatic string vec_tag(int k);
        case (k)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R11";
            4: return "R5";
            5: return "R6";
            6: return "R3";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic pulse_act(bit use_rx);
        if (use_rx) rx = 1'b1; else tx = 1'b1;
        tick();
        tx = 1'b0;
        rx = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        int dark_len;
        tick(3);
        rst = 1'b0;
        #1;
        // R1: every pin starts as input
        chk("R1 oe", {29'd0, pad_oe}, 32'd0);
        tick();
        chk("R1 oe hold", {29'd0, pad_oe}, 32'd0);

        for (int k = 0; k < NV; k++) begin
            cfg_wr = 1'b1;
            cfg_mode = VEC[k][18:13];
            cfg_dout = VEC[k][12:10];
            {link, spd, aneg, fdx} = VEC[k][9:6];
            tick();
            cfg_wr = 1'b0;
            #1;
            chk({vec_tag(k), " pad_o"}, {29'd0, pad_o}, {29'd0, VEC[k][5:3]});
            chk({vec_tag(k), " pad_oe"}, {29'd0, pad_oe}, {29'd0, VEC[k][2:0]});
        end

        // All pins LED, link up at 100M full duplex
        cfg_wr = 1'b1; cfg_mode = 6'b11_11_11; cfg_dout = 3'b000;
        link = 1'b1; spd = 1'b1; aneg = 1'b0; fdx = 1'b1;
        tick();
        cfg_wr = 1'b0;
        tick();
        chk("R1 R6 idle lit", {31'd0, pad_oe[1]}, 32'd1);

        // R7 R13 R8: single strobe
        pulse_act(1'b0);
        chk("R7 dark start", {31'd0, pad_oe[1]}, 32'd0);
        dark_len = 1;
        while (!pad_oe[1] && dark_len < 100) begin
            tick();
            if (!pad_oe[1]) dark_len++;
        end
        chk("R13 dark length", dark_len, IVL);
        tick(IVL - 1);
        chk("R8 hold lit end", {31'd0, pad_oe[1]}, 32'd1);
        tick();
        chk("R8 idle after hold", {31'd0, pad_oe[1]}, 32'd1);
        tick(5);

        // R9: strobes inside dark period and hold -> exactly one more blink
        pulse_act(1'b1);                 // dark from now (t=1)
        tick(2);
        pulse_act(1'b0);                 // inside dark, t=4
        pulse_act(1'b1);                 // inside dark, t=5
        tick(IVL - 5 + 3);               // t=IVL+3, inside hold
        chk("R8 hold ignores traffic", {31'd0, pad_oe[1]}, 32'd1);
        pulse_act(1'b0);                 // t=IVL+4
        chk("R8 hold not shortened", {31'd0, pad_oe[1]}, 32'd1);
        tick(IVL - 4);                   // t=2*IVL
        chk("R9 still in hold", {31'd0, pad_oe[1]}, 32'd1);
        tick();                          // t=2*IVL+1
        chk("R9 pending blink", {31'd0, pad_oe[1]}, 32'd0);
        tick(IVL - 1);
        chk("R13 pending dark end", {31'd0, pad_oe[1]}, 32'd0);
        tick();
        chk("R9 second hold", {31'd0, pad_oe[1]}, 32'd1);
        tick(IVL + 6);
        chk("R9 only one extra blink", {31'd0, pad_oe[1]}, 32'd1);

        // R10: drop link with a request pending
        pulse_act(1'b0);
        tick();
        pulse_act(1'b1);                 // pending
        link = 1'b0;
        #1;
        chk("R10 dark at once", {31'd0, pad_oe[1]}, 32'd0);
        tick();
        link = 1'b1;
        #1;
        chk("R10 lit on return", {31'd0, pad_oe[1]}, 32'd1);
        tick(3 * IVL);
        chk("R10 pending cleared", {31'd0, pad_oe[1]}, 32'd1);

        // R6: traffic with link down starts nothing
        link = 1'b0;
        tick();
        pulse_act(1'b0);
        link = 1'b1;
        #1;
        chk("R6 no blink from down traffic", {31'd0, pad_oe[1]}, 32'd1);
        tick(2);
        chk("R6 steady", {31'd0, pad_oe[1]}, 32'd1);

        // R12: input synchronizer latency
        cfg_wr = 1'b1; cfg_mode = 6'b00_00_00;
        tick();
        cfg_wr = 1'b0;
        pad_in = 3'b000;
        tick(3);
        pad_in = 3'b101;
        tick();
        chk("R12 one edge old", {29'd0, gin}, 32'd0);
        tick();
        chk("R12 two edges", {29'd0, gin}, 32'h5);
        chk("R3 input released", {29'd0, pad_oe}, 32'd0);

        finish_run();
    end
endmodule